// File: doc/BRIEF.md
# UART Modem Loopback Router

This block sits between a UART's serial core and its external pins. It routes the serial data lines and the modem handshake lines, and it holds the modem control register that drives those lines. In normal mode, the transmit stream goes to the TX pin and the RX pin feeds the receiver. The four outputs, active low, follow the control bits. The four modem status pins, also active low, are synchronized and reported as true-sense status.

Setting the loopback bit in the control register turns on a self-test path. The TX pin goes to idle mark, and the transmitter's output is fed straight back into the receiver input. The control outputs are parked inactive. The four status inputs no longer come from the pins; they take a fixed cross-mapping of the four control bits. Software can then write a byte to the transmitter and read it back, and it can toggle control bits and watch the matching status and change flags respond. The serializer, the deserializer and the baud timing attach through `tx_out` and `rx_in`.

The mode is held by a two-state machine. MODE_NORMAL moves to MODE_LOOP on the transition ENTER_LOOP, which is a control write with bit 4 set. MODE_LOOP moves back to MODE_NORMAL on the transition LEAVE_LOOP, which is a control write with bit 4 clear. Any other write keeps the current state.

Top module: `uart_lpbk_router`

## Requirements
- R1: After reset, the control register reads 0x00, the status register reads 0x00 while all status pins are high, all four control output pins are high, and `pin_tx` follows `tx_out`.
- R2: Address 0 is the control register. Writes store bits 4:0, and reads return them with bits 7:5 as 0. Address 1 is the status register, which is read only.
- R3: In normal mode, `pin_tx` equals `tx_out` and `rx_in` equals `pin_rx`.
- R4: In normal mode, `pin_dtr_n`, `pin_rts_n`, `pin_out1_n` and `pin_out2_n` are the inverse of control bits 0, 1, 2 and 3 respectively.
- R5: In loopback mode, `rx_in` equals `tx_out`, `pin_tx` is 1, and `pin_rx` has no effect.
- R6: In loopback mode, all four control output pins are held at 1, whatever the control bits are.
- R7: In loopback mode, status bit 4 (CTS) takes control bit 0, bit 5 (DSR) takes bit 1, bit 6 (RI) takes bit 2, and bit 7 (CD) takes bit 3, one clock after the control value. The four status pins are ignored.
- R8: In normal mode, status bits 4..7 are the inverse of the pins `pin_cts_n`, `pin_dsr_n`, `pin_ri_n` and `pin_cd_n`, after SYNC_STAGES+1 clock edges.
- R9: Status bit 0 sets on any change of CTS, bit 1 on any change of DSR, and bit 3 on any change of CD. Bit 2 sets only when RI goes from true to false.
- R10: A read of the status register clears bits 3:0 at that clock edge. A change that is registered at the same edge sets its bit anyway.
- R11: A control write switches the mode at the write's clock edge. The switch itself updates the status bits, and the change flags on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 1 | Register select: 0 = control, 1 = status |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (a status read clears the change flags) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| tx_out | input | 1 | Serial stream from the transmitter |
| rx_in | output | 1 | Serial stream to the receiver |
| pin_tx | output | 1 | TX pin |
| pin_rx | input | 1 | RX pin |
| pin_cts_n | input | 1 | CTS pin, active low |
| pin_dsr_n | input | 1 | DSR pin, active low |
| pin_cd_n | input | 1 | CD pin, active low |
| pin_ri_n | input | 1 | RI pin, active low |
| pin_dtr_n | output | 1 | DTR pin, active low |
| pin_rts_n | output | 1 | RTS pin, active low |
| pin_out1_n | output | 1 | General-purpose output pin, active low |
| pin_out2_n | output | 1 | Interrupt-enable output pin, active low |

## Verification
The bench builds the block with the default SYNC_STAGES = 2. This makes the pin-to-status latency exactly three edges, so the bench can time a status read to fall on the same edge as a pin change and check that the new flag wins over the clear. With a short chain, the bench can also step through a table of pin patterns in a few cycles each. The mode switches and the loopback cross-mapping depend on no parameter, so they are reached directly with control writes.

// File: rtl/uart_lpbk_pkg.sv
package uart_lpbk_pkg;
    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_LOOP   = 1'b1
    } lb_mode_e;

    localparam int REG_W     = 8;
    localparam int CTL_BITS  = 4;
    localparam int ADDR_W    = 1;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 1'b0;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 1'b1;

    // control register bit positions
    localparam int CB_DTR  = 0;
    localparam int CB_RTS  = 1;
    localparam int CB_AUX  = 2;
    localparam int CB_IREN = 3;
    localparam int CB_LOOP = 4;

    // live status vector order: 0 cts, 1 dsr, 2 ri, 3 cd
    localparam int SI_CTS = 0;
    localparam int SI_DSR = 1;
    localparam int SI_RI  = 2;
    localparam int SI_CD  = 3;
endpackage

// File: rtl/lpbk_pin_sync.sv
module lpbk_pin_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [WIDTH-1:0] stage_q [STAGES];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
                end else begin
                    stage_q[0] <= d;
                    for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
                end
            end
            assign q = stage_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/lpbk_mode_ctrl.sv
module lpbk_mode_ctrl
    import uart_lpbk_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wdata,
    output logic [CTL_BITS-1:0] ctrl_bits,
    output logic                loop_on
);
    lb_mode_e state_q, state_d;

    // next-state selection: ENTER_LOOP / LEAVE_LOOP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_NORMAL: if (wr_en &&  wdata[CB_LOOP]) state_d = MODE_LOOP;
            MODE_LOOP:   if (wr_en && !wdata[CB_LOOP]) state_d = MODE_NORMAL;
            default:     state_d = MODE_NORMAL;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_NORMAL;
        else        state_q <= state_d;
    end

    // control bits beside the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ctrl_bits <= '0;
        else if (wr_en) ctrl_bits <= wdata[CTL_BITS-1:0];
    end

    // outputs
    always_comb begin
        unique case (state_q)
            MODE_LOOP: loop_on = 1'b1;
            default:   loop_on = 1'b0;
        endcase
    end
endmodule

// File: rtl/lpbk_modem_status.sv
module lpbk_modem_status
    import uart_lpbk_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CTL_BITS-1:0] live,
    input  logic                rd_clr,
    output logic [REG_W-1:0]    stat
);
    logic [CTL_BITS-1:0] cur_q, flag_q, evt;

    always_comb begin
        evt          = live ^ cur_q;
        evt[SI_RI]   = cur_q[SI_RI] & ~live[SI_RI];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            flag_q <= '0;
        end else begin
            cur_q  <= live;
            flag_q <= (rd_clr ? '0 : flag_q) | evt;
        end
    end

    assign stat = {cur_q, flag_q};
endmodule

// File: rtl/uart_lpbk_router.sv
module uart_lpbk_router
    import uart_lpbk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       tx_out,
    output logic       rx_in,
    output logic       pin_tx,
    input  logic       pin_rx,
    input  logic       pin_cts_n,
    input  logic       pin_dsr_n,
    input  logic       pin_cd_n,
    input  logic       pin_ri_n,
    output logic       pin_dtr_n,
    output logic       pin_rts_n,
    output logic       pin_out1_n,
    output logic       pin_out2_n
);
    logic                wr_ctrl, rd_stat, loop_on;
    logic [CTL_BITS-1:0] ctrl_bits, pins_n, pins_s_n, live_bits;
    logic [REG_W-1:0]    stat_word;

    assign wr_ctrl = reg_wr && (reg_addr == CTRL_ADDR);
    assign rd_stat = reg_rd && (reg_addr == STAT_ADDR);

    lpbk_mode_ctrl u_mode (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl), .wdata(reg_wdata),
        .ctrl_bits(ctrl_bits), .loop_on(loop_on)
    );

    assign pins_n = {pin_cd_n, pin_ri_n, pin_dsr_n, pin_cts_n};

    lpbk_pin_sync #(.STAGES(SYNC_STAGES), .WIDTH(CTL_BITS), .RST_VAL('1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pins_n), .q(pins_s_n)
    );

    // loopback cross-map: cts<-dtr, dsr<-rts, ri<-aux, cd<-iren
    always_comb begin
        if (loop_on) begin
            live_bits[SI_CTS] = ctrl_bits[CB_DTR];
            live_bits[SI_DSR] = ctrl_bits[CB_RTS];
            live_bits[SI_RI]  = ctrl_bits[CB_AUX];
            live_bits[SI_CD]  = ctrl_bits[CB_IREN];
        end else begin
            live_bits = ~pins_s_n;
        end
    end

    lpbk_modem_status u_stat (
        .clk(clk), .rst_n(rst_n), .live(live_bits), .rd_clr(rd_stat), .stat(stat_word)
    );

    assign rx_in      = loop_on ? tx_out : pin_rx;
    assign pin_tx     = loop_on ? 1'b1   : tx_out;
    assign pin_dtr_n  = loop_on | ~ctrl_bits[CB_DTR];
    assign pin_rts_n  = loop_on | ~ctrl_bits[CB_RTS];
    assign pin_out1_n = loop_on | ~ctrl_bits[CB_AUX];
    assign pin_out2_n = loop_on | ~ctrl_bits[CB_IREN];

    assign reg_rdata = (reg_addr == STAT_ADDR) ? stat_word
                                               : {3'b000, loop_on, ctrl_bits};
endmodule

// File: rtl/uart_lpbk_router_chk.sv
module uart_lpbk_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       loop_on,
    input logic [3:0] ctrl_bits,
    input logic [3:0] live_bits,
    input logic [7:0] stat_word,
    input logic       rd_stat,
    input logic       tx_out,
    input logic       rx_in,
    input logic       pin_tx,
    input logic       pin_rx,
    input logic       pin_dtr_n,
    input logic       pin_rts_n,
    input logic       pin_out1_n,
    input logic       pin_out2_n
);
    assert_pass_normal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_on |-> (pin_tx == tx_out && rx_in == pin_rx));

    assert_loop_serial_R5: assert property (@(posedge clk) disable iff (!rst_n)
        loop_on |-> (rx_in == tx_out && pin_tx == 1'b1));

    assert_outs_parked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        loop_on |-> ({pin_dtr_n, pin_rts_n, pin_out1_n, pin_out2_n} == 4'hF));

    assert_loop_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
        loop_on |=> (stat_word[7:4] == $past(ctrl_bits)));

    assert_ri_trail_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_word[6]) |-> stat_word[2]);

    assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && live_bits == stat_word[7:4]) |=> (stat_word[3:0] == 4'h0));
endmodule

bind uart_lpbk_router uart_lpbk_router_chk u_chk (
    .clk(clk), .rst_n(rst_n), .loop_on(loop_on), .ctrl_bits(ctrl_bits),
    .live_bits(live_bits), .stat_word(stat_word), .rd_stat(rd_stat),
    .tx_out(tx_out), .rx_in(rx_in), .pin_tx(pin_tx), .pin_rx(pin_rx),
    .pin_dtr_n(pin_dtr_n), .pin_rts_n(pin_rts_n),
    .pin_out1_n(pin_out1_n), .pin_out2_n(pin_out2_n)
);

// File: tb/tb_uart_lpbk_router.sv
module tb_uart_lpbk_router;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_addr = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic tx_out = 1'b1, rx_in, pin_tx, pin_rx = 1'b1;
    logic pin_cts_n = 1'b1, pin_dsr_n = 1'b1, pin_cd_n = 1'b1, pin_ri_n = 1'b1;
    logic pin_dtr_n, pin_rts_n, pin_out1_n, pin_out2_n;
    int   checks = 0, errors = 0;
    bit   done = 1'b0;
    logic [7:0] rd_val;

    always #5 clk = ~clk;

    uart_lpbk_router #(.SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_out(tx_out), .rx_in(rx_in),
        .pin_tx(pin_tx), .pin_rx(pin_rx), .pin_cts_n(pin_cts_n), .pin_dsr_n(pin_dsr_n),
        .pin_cd_n(pin_cd_n), .pin_ri_n(pin_ri_n), .pin_dtr_n(pin_dtr_n),
        .pin_rts_n(pin_rts_n), .pin_out1_n(pin_out1_n), .pin_out2_n(pin_out2_n)
    );

    // pins {ri_n, cd_n, dsr_n, cts_n} -> expected status[7:4] {cd, ri, dsr, cts}
    localparam logic [7:0] VEC [6] = '{
        {4'b1110, 4'b0001}, {4'b1101, 4'b0010}, {4'b1011, 4'b1000},
        {4'b0111, 4'b0100}, {4'b0000, 4'b1111}, {4'b1111, 4'b0000}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(negedge clk);
        reg_addr = 1'b0; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_pins(input logic [3:0] p);
        {pin_ri_n, pin_cd_n, pin_dsr_n, pin_cts_n} = p;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #200000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        // R1: reset state
        rd_reg(1'b0, rd_val); check("R1 ctrl", rd_val, 8'h00);
        rd_reg(1'b1, rd_val); check("R1 stat", rd_val, 8'h00);
        check("R1 outs", {4'h0, pin_dtr_n, pin_rts_n, pin_out1_n, pin_out2_n}, 8'h0F);
        tx_out = 1'b0; #1 check("R1 tx", {7'h0, pin_tx}, 8'h00);

        // R8: table walk, normal mode
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); set_pins(VEC[k][7:4]);
            wait_cyc(4);
            rd_reg(1'b1, rd_val);
            check("R8 pins", {rd_val[7:4], 4'h0}, {VEC[k][3:0], 4'h0});
        end
        rd_reg(1'b1, rd_val); check("R10 cleared", rd_val, 8'h00);

        // R3: pass-through
        tx_out = 1'b1; pin_rx = 1'b0; #1
        check("R3 pass", {6'h0, pin_tx, rx_in}, 8'h02);
        // R4: outputs follow control
        wr_ctrl(8'h05); #1
        check("R4 outs", {4'h0, pin_dtr_n, pin_rts_n, pin_out1_n, pin_out2_n}, 8'h05);
        rd_reg(1'b0, rd_val); check("R2 ctrl rb", rd_val, 8'h05);

        // R9: RI leading edge no flag, trailing edge flag
        @(negedge clk); pin_ri_n = 1'b0; wait_cyc(4);
        rd_reg(1'b1, rd_val); check("R9 ri lead", rd_val, 8'h40);
        @(negedge clk); pin_ri_n = 1'b1; wait_cyc(4);
        rd_reg(1'b1, rd_val); check("R9 ri trail", rd_val, 8'h04);
        rd_reg(1'b1, rd_val); check("R10 clr", rd_val, 8'h00);

        // R10: change registered on the read edge wins over the clear
        @(negedge clk); pin_cts_n = 1'b0;
        @(negedge clk);
        rd_reg(1'b1, rd_val); check("R10 same edge rd", rd_val, 8'h00);
        rd_reg(1'b1, rd_val); check("R10 set wins", rd_val, 8'h11);
        @(negedge clk); pin_cts_n = 1'b1; wait_cyc(4);
        rd_reg(1'b1, rd_val);

        // R11 / R2: enter loop, readback masks upper bits
        wr_ctrl(8'hFF);
        rd_reg(1'b0, rd_val); check("R2 mask", rd_val, 8'h1F);
        // R6
        check("R6 parked", {4'h0, pin_dtr_n, pin_rts_n, pin_out1_n, pin_out2_n}, 8'h0F);
        // R5
        tx_out = 1'b0; pin_rx = 1'b1; #1
        check("R5 loop0", {6'h0, pin_tx, rx_in}, 8'h02);
        tx_out = 1'b1; pin_rx = 1'b0; #1
        check("R5 loop1", {6'h0, pin_tx, rx_in}, 8'h03);
        // R11: switch visible in status with flags (ri rises: no flag)
        rd_reg(1'b1, rd_val); check("R11 enter", rd_val, 8'hFB);
        // R7: pins ignored
        @(negedge clk); set_pins(4'b0000); wait_cyc(4);
        rd_reg(1'b1, rd_val); check("R7 pins ignored", rd_val, 8'hF0);
        wr_ctrl(8'h15); @(negedge clk);
        rd_reg(1'b1, rd_val); check("R7 map", rd_val, 8'h5A);
        wr_ctrl(8'h11); @(negedge clk);
        rd_reg(1'b1, rd_val); check("R9 loop teri", rd_val, 8'h14);
        wr_ctrl(8'h1F); @(negedge clk);
        rd_reg(1'b1, rd_val);
        @(negedge clk); set_pins(4'b1111);

        // R11: leave loop
        wr_ctrl(8'h00); #1
        check("R11 tx back", {7'h0, pin_tx}, {7'h0, tx_out});
        wait_cyc(4);
        rd_reg(1'b1, rd_val); check("R11 leave", rd_val, 8'h0F);
        rd_reg(1'b0, rd_val); check("R11 ctrl", rd_val, 8'h00);

        finish_run();
    end
endmodule